// File: doc/BRIEF.md
# Bus Cycle Break Condition Unit

This block watches a processor bus and raises a break request when a bus cycle meets a programmed condition. Each completed bus cycle comes in as a one-cycle observation: address, data, access size and direction, marked by `mon_valid`. The block compares each observation against a set of channel conditions. A channel condition may test the address, the data or both, and it may be limited to reads or to writes. A data condition is tied to an access size.

There are three modes. In normal mode, any channel that matches causes a break. In range mode, any access whose address falls inside a programmed window also causes a break. In sequential mode, the channels must match in ascending order. An optional reset-point address returns the sequence to its first channel. The highest-numbered channel has a pass counter, so it breaks only on every N-th match. The break output is a one-cycle pulse.

Configuration is written through a plain register write port. Every write clears the sequence stage and the pass counter. The observation input has no ready signal. The block samples every cycle on which `mon_valid` is high and never applies back-pressure. The bus side therefore only needs to hold each observation for one clock.

Top module: `bus_break_unit`

## Requirements
- R1: A bus cycle that satisfies an enabled channel's address-only condition produces `brk_pulse` high on the clock after that cycle, for exactly one cycle. An address-only condition matches any access size. With no `mon_valid`, `brk_pulse` stays low.
- R2: A data condition of byte size (size code 0) compares only data bits [7:0]. It matches only byte accesses, at any address alignment.
- R3: A word data condition (size code 1) compares bits [15:0] and matches only word accesses. A longword data condition (size code 2) compares all 32 bits and matches only longword accesses.
- R4: `cfg_err[c]` is high exactly when channel c is enabled and its condition address is misaligned for its size. Misaligned means a nonzero bit 0 for word, nonzero bits [1:0] for longword, or size code 3 at any address. A flagged channel never matches.
- R5: The direction field (ctrl bits [5:4]) restricts a channel: code 1 matches reads only (`mon_write`=0), code 2 matches writes only, and codes 0 and 3 match either direction.
- R6: The last channel (index NCH-1) breaks only on every N-th match, where N is the pass count register (address 0x14). A pass count of 0 acts as 1.
- R7: In sequential mode (mode bit 0), a match on channel k advances the stage only while the stage is k. A match on a channel out of turn has no effect. A break occurs only when the last channel matches at the last stage, and the stage then returns to channel 0.
- R8: With sequential mode and the reset-point enable (mode bit 2) both set, an access at the reset-point address (0x13) returns the stage to channel 0 and clears the pass counter. This takes priority over a last-channel match in the same cycle. Without sequential mode the reset point has no effect.
- R9: In range mode (mode bit 1) without sequential mode, an access with address between 0x11 (low) and 0x12 (high), bounds inclusive, breaks. When sequential mode is also set, the range comparison is ignored.
- R10: Any configuration write clears the sequence stage and the pass counter.

Register map (`cfg_sel`):
- Channel c uses 4c+0 for the address, 4c+1 for the data and 4c+2 for control.
- Control word bits: [1:0] size, [2] address enable, [3] data enable, [5:4] direction, [6] channel enable.
- Global registers: 0x10 mode, 0x11 range low, 0x12 range high, 0x13 reset-point address, 0x14 pass count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 5 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| mon_valid | input | 1 | A completed bus cycle is presented this clock |
| mon_addr | input | 32 | Bus cycle address |
| mon_data | input | 32 | Bus cycle data, right-justified |
| mon_size | input | 2 | Access size: 0 byte, 1 word, 2 longword |
| mon_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| brk_pulse | output | 1 | One-cycle break request |
| cfg_err | output | NCH | Per-channel misalignment flag |

## Verification
The hardest state to reach is the sequencer sitting at its last stage when the reset-point address equals the last channel's address. In that case two conditions compete in one cycle. The bench first walks the sequence through channels 0 to 2 with single bus cycles, then presents that shared address, and expects no break. It also interrupts partly counted passes with a harmless configuration write, which shows that the clear takes effect at the ports. Size and alignment behaviour is covered by complete sweeps of condition size against access size and address offset.

// File: rtl/bcb_pkg.sv
package bcb_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    DIR_ANY   = 2'd0,
    DIR_READ  = 2'd1,
    DIR_WRITE = 2'd2,
    DIR_ANY2  = 2'd3
  } dir_qual_e;

  // Field order matches control word bits [6:0].
  typedef struct packed {
    logic      en;
    dir_qual_e dir;
    logic      dat_en;
    logic      adr_en;
    acc_size_e size;
  } ch_ctrl_t;

  localparam int CTRL_W = 7;

  // Global register selects.
  localparam logic [4:0] SEL_MODE  = 5'h10;
  localparam logic [4:0] SEL_RLO   = 5'h11;
  localparam logic [4:0] SEL_RHI   = 5'h12;
  localparam logic [4:0] SEL_RP    = 5'h13;
  localparam logic [4:0] SEL_PASS  = 5'h14;

endpackage

// File: rtl/bcb_cfg_regs.sv
module bcb_cfg_regs
  import bcb_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int CW   = 32,
  parameter int CNTW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [4:0]              cfg_sel,
  input  logic [CW-1:0]           cfg_wdata,
  output logic [NCH-1:0][AW-1:0]  ch_addr,
  output logic [NCH-1:0][DW-1:0]  ch_data,
  output ch_ctrl_t [NCH-1:0]      ch_ctrl,
  output logic                    seq_en,
  output logic                    rng_en,
  output logic                    rp_en,
  output logic [AW-1:0]           rng_lo,
  output logic [AW-1:0]           rng_hi,
  output logic [AW-1:0]           rp_addr,
  output logic [CNTW-1:0]         pass_cnt
);

  localparam int REGS_PER_CH = 4;

  for (genvar c = 0; c < NCH; c++) begin : g_chreg
    localparam logic [4:0] BASE = 5'(REGS_PER_CH * c);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_addr[c] <= '0;
        ch_data[c] <= '0;
        ch_ctrl[c] <= '0;
      end else if (cfg_we) begin
        if (cfg_sel == BASE)         ch_addr[c] <= cfg_wdata[AW-1:0];
        if (cfg_sel == BASE + 5'd1)  ch_data[c] <= cfg_wdata[DW-1:0];
        if (cfg_sel == BASE + 5'd2)  ch_ctrl[c] <= ch_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_en   <= 1'b0;
      rng_en   <= 1'b0;
      rp_en    <= 1'b0;
      rng_lo   <= '0;
      rng_hi   <= '0;
      rp_addr  <= '0;
      pass_cnt <= '0;
    end else if (cfg_we) begin
      unique case (cfg_sel)
        SEL_MODE: begin
          seq_en <= cfg_wdata[0];
          rng_en <= cfg_wdata[1];
          rp_en  <= cfg_wdata[2];
        end
        SEL_RLO:  rng_lo   <= cfg_wdata[AW-1:0];
        SEL_RHI:  rng_hi   <= cfg_wdata[AW-1:0];
        SEL_RP:   rp_addr  <= cfg_wdata[AW-1:0];
        SEL_PASS: pass_cnt <= cfg_wdata[CNTW-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/bcb_chan_cmp.sv
module bcb_chan_cmp
  import bcb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          mon_valid,
  input  logic [AW-1:0] mon_addr,
  input  logic [DW-1:0] mon_data,
  input  acc_size_e     mon_size,
  input  logic          mon_write,
  input  logic [AW-1:0] cond_addr,
  input  logic [DW-1:0] cond_data,
  input  ch_ctrl_t      cond_ctrl,
  output logic          misalign,
  output logic          hit
);

  logic [DW-1:0] lane_mask;
  logic          addr_ok;
  logic          data_ok;
  logic          dir_ok;
  logic          bad_align;

  always_comb begin
    unique case (cond_ctrl.size)
      SZ_BYTE: bad_align = 1'b0;
      SZ_WORD: bad_align = cond_addr[0];
      SZ_LONG: bad_align = |cond_addr[1:0];
      default: bad_align = 1'b1;
    endcase
  end

  always_comb begin
    unique case (cond_ctrl.size)
      SZ_BYTE: lane_mask = DW'(8'hFF);
      SZ_WORD: lane_mask = DW'(16'hFFFF);
      default: lane_mask = '1;
    endcase
  end

  always_comb begin
    unique case (cond_ctrl.dir)
      DIR_READ:  dir_ok = !mon_write;
      DIR_WRITE: dir_ok = mon_write;
      default:   dir_ok = 1'b1;
    endcase
  end

  assign addr_ok  = !cond_ctrl.adr_en || (mon_addr == cond_addr);
  assign data_ok  = !cond_ctrl.dat_en ||
                    ((mon_size == cond_ctrl.size) &&
                     ((mon_data & lane_mask) == (cond_data & lane_mask)));
  assign misalign = cond_ctrl.en && bad_align;
  assign hit      = mon_valid && cond_ctrl.en && !bad_align &&
                    (cond_ctrl.adr_en || cond_ctrl.dat_en) &&
                    addr_ok && data_ok && dir_ok;

endmodule

// File: rtl/bcb_seq_ctl.sv
module bcb_seq_ctl #(
  parameter int NCH  = 4,
  parameter int AW   = 32,
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            mon_valid,
  input  logic [AW-1:0]   mon_addr,
  input  logic [NCH-1:0]  hit,
  input  logic            seq_en,
  input  logic            rng_en,
  input  logic            rp_en,
  input  logic [AW-1:0]   rng_lo,
  input  logic [AW-1:0]   rng_hi,
  input  logic [AW-1:0]   rp_addr,
  input  logic [CNTW-1:0] pass_cnt,
  output logic            brk_pulse
);

  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [SW-1:0] LAST = SW'(NCH - 1);

  logic [SW-1:0]   stage, stage_n;
  logic [CNTW-1:0] cnt, cnt_n;
  logic [CNTW:0]   cnt_inc, pass_tgt;
  logic            last_arm, last_fire, rp_hit, rng_hit, early_hit, fire;

  assign cnt_inc  = {1'b0, cnt} + 1'b1;
  assign pass_tgt = (pass_cnt == '0) ? (CNTW+1)'(1) : {1'b0, pass_cnt};
  assign rp_hit   = seq_en && rp_en && mon_valid && (mon_addr == rp_addr);
  assign rng_hit  = rng_en && mon_valid && (mon_addr >= rng_lo) && (mon_addr <= rng_hi);
  assign early_hit = (NCH > 1) ? |hit[NCH-2:0] : 1'b0;

  always_comb begin
    last_arm  = seq_en ? (hit[NCH-1] && stage == LAST) : hit[NCH-1];
    last_fire = last_arm && (cnt_inc == pass_tgt);
    stage_n   = stage;
    cnt_n     = cnt;
    fire      = 1'b0;
    if (seq_en) begin
      if (rp_hit) begin
        stage_n = '0;
        cnt_n   = '0;
      end else if (stage != LAST && hit[stage]) begin
        stage_n = stage + 1'b1;
      end else if (last_arm) begin
        if (last_fire) begin
          fire    = 1'b1;
          stage_n = '0;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_inc[CNTW-1:0];
        end
      end
    end else begin
      stage_n = '0;
      if (last_arm) cnt_n = last_fire ? '0 : cnt_inc[CNTW-1:0];
      fire = early_hit || rng_hit || last_fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage     <= '0;
      cnt       <= '0;
      brk_pulse <= 1'b0;
    end else if (clr) begin
      stage     <= '0;
      cnt       <= '0;
      brk_pulse <= 1'b0;
    end else begin
      stage     <= stage_n;
      cnt       <= cnt_n;
      brk_pulse <= fire;
    end
  end

  // R7: the stage only steps forward by one or returns to the start.
  p_stage_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stage != $past(stage)) |-> (stage == '0 || stage == SW'($past(stage) + 1'b1)));

  // R7: without a bus cycle or a write, the stage holds.
  p_stage_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_valid && !clr) |=> $stable(stage));

  // R10: a configuration write leaves stage and counter at zero.
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (stage == '0 && cnt == '0 && !brk_pulse));

  // R6: the pass counter never reaches its target value.
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt} < pass_tgt));

  // R1: a break always follows an observed bus cycle.
  p_break_needs_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_valid |=> !brk_pulse);

endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import bcb_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int CNTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [4:0]     cfg_sel,
  input  logic [31:0]    cfg_wdata,
  input  logic           mon_valid,
  input  logic [AW-1:0]  mon_addr,
  input  logic [DW-1:0]  mon_data,
  input  logic [1:0]     mon_size,
  input  logic           mon_write,
  output logic           brk_pulse,
  output logic [NCH-1:0] cfg_err
);

  localparam int CW = 32;

  logic [NCH-1:0][AW-1:0] ch_addr;
  logic [NCH-1:0][DW-1:0] ch_data;
  ch_ctrl_t [NCH-1:0]     ch_ctrl;
  logic [NCH-1:0]         ch_hit;
  logic                   seq_en, rng_en, rp_en;
  logic [AW-1:0]          rng_lo, rng_hi, rp_addr;
  logic [CNTW-1:0]        pass_cnt;
  acc_size_e              size_q;

  assign size_q = acc_size_e'(mon_size);

  bcb_cfg_regs #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW), .CNTW(CNTW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .ch_addr  (ch_addr),
    .ch_data  (ch_data),
    .ch_ctrl  (ch_ctrl),
    .seq_en   (seq_en),
    .rng_en   (rng_en),
    .rp_en    (rp_en),
    .rng_lo   (rng_lo),
    .rng_hi   (rng_hi),
    .rp_addr  (rp_addr),
    .pass_cnt (pass_cnt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    bcb_chan_cmp #(.AW(AW), .DW(DW)) u_cmp (
      .mon_valid(mon_valid),
      .mon_addr (mon_addr),
      .mon_data (mon_data),
      .mon_size (size_q),
      .mon_write(mon_write),
      .cond_addr(ch_addr[c]),
      .cond_data(ch_data[c]),
      .cond_ctrl(ch_ctrl[c]),
      .misalign (cfg_err[c]),
      .hit      (ch_hit[c])
    );

    // R4: a flagged channel never reports a match.
    p_err_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err[c] |-> !ch_hit[c]);
  end

  bcb_seq_ctl #(.NCH(NCH), .AW(AW), .CNTW(CNTW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cfg_we),
    .mon_valid(mon_valid),
    .mon_addr (mon_addr),
    .hit      (ch_hit),
    .seq_en   (seq_en),
    .rng_en   (rng_en),
    .rp_en    (rp_en),
    .rng_lo   (rng_lo),
    .rng_hi   (rng_hi),
    .rp_addr  (rp_addr),
    .pass_cnt (pass_cnt),
    .brk_pulse(brk_pulse)
  );

  // R9: with sequential mode on, no break without some channel matching.
  p_seq_ignores_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_en && !cfg_we && ch_hit == '0) |=> !brk_pulse);

endmodule

// File: tb/tb_bus_break_unit.sv
module tb_bus_break_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        mon_valid = 1'b0;
  logic [31:0] mon_addr = '0;
  logic [31:0] mon_data = '0;
  logic [1:0]  mon_size = '0;
  logic        mon_write = 1'b0;
  logic        brk_pulse;
  logic [3:0]  cfg_err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bus_break_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mon_valid(mon_valid), .mon_addr(mon_addr),
    .mon_data(mon_data), .mon_size(mon_size), .mon_write(mon_write),
    .brk_pulse(brk_pulse), .cfg_err(cfg_err)
  );

  function automatic logic [31:0] ctl(input logic en, input logic [1:0] dir,
                                      input logic de, input logic ae, input logic [1:0] sz);
    return {25'd0, en, dir, de, ae, sz};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic bus(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                     input logic w, output logic got);
    @(negedge clk);
    mon_valid = 1'b1; mon_addr = a; mon_data = d; mon_size = sz; mon_write = w;
    @(negedge clk);
    mon_valid = 1'b0;
    got = brk_pulse;
  endtask

  task automatic clear_all();
    for (int c = 0; c < 4; c++) wr(5'(4*c+2), 32'd0);
    wr(5'h10, 32'd0);
    wr(5'h14, 32'd0);
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic g;
    repeat (3) @(negedge clk);
    chk("R1 reset brk", {31'd0, brk_pulse}, 32'd0);
    chk("R4 reset err", {28'd0, cfg_err}, 32'd0);
    rst_n = 1'b1;

    // R4 / R1: size x address offset sweep on channel 0, address only.
    for (int sz = 0; sz < 4; sz++) begin
      for (int off = 0; off < 4; off++) begin
        logic e;
        e = (sz == 3) || (sz == 2 && off != 0) || (sz == 1 && off[0]);
        wr(5'h00, 32'h100 + off);
        wr(5'h02, ctl(1'b1, 2'd0, 1'b0, 1'b1, 2'(sz)));
        @(negedge clk);
        chk("R4 err flag", {31'd0, cfg_err[0]}, {31'd0, e});
        bus(32'h100 + off, 32'h0, 2'd0, 1'b0, g);
        chk("R4/R1 match gated", {31'd0, g}, {31'd0, !e});
        @(negedge clk);
        chk("R1 single pulse", {31'd0, brk_pulse}, 32'd0);
      end
    end
    bus(32'h104, 32'h0, 2'd2, 1'b1, g);
    chk("R1 no hit other addr", {31'd0, g}, 32'd0);
    clear_all();

    // R2 / R3: data condition size vs access size vs address offset.
    wr(5'h04, 32'h200);
    wr(5'h05, 32'h11223344);
    for (int cs = 0; cs < 3; cs++) begin
      wr(5'h06, ctl(1'b1, 2'd0, 1'b1, 1'b0, 2'(cs)));
      for (int as = 0; as < 3; as++) begin
        for (int off = 0; off < 4; off++) begin
          bus(32'h300 + off, 32'h11223344, 2'(as), 1'b0, g);
          chk(cs == 0 ? "R2 byte size sweep" : "R3 word/long size sweep",
              {31'd0, g}, {31'd0, as == cs});
        end
      end
    end
    wr(5'h06, ctl(1'b1, 2'd0, 1'b1, 1'b0, 2'd0));
    bus(32'h301, 32'hDEADBE44, 2'd0, 1'b1, g);
    chk("R2 byte lane only", {31'd0, g}, 32'd1);
    bus(32'h301, 32'h11223345, 2'd0, 1'b1, g);
    chk("R2 byte mismatch", {31'd0, g}, 32'd0);
    wr(5'h06, ctl(1'b1, 2'd0, 1'b1, 1'b0, 2'd1));
    bus(32'h302, 32'hFFFF3344, 2'd1, 1'b0, g);
    chk("R3 word lanes only", {31'd0, g}, 32'd1);
    wr(5'h06, ctl(1'b1, 2'd0, 1'b1, 1'b0, 2'd2));
    bus(32'h300, 32'h10223344, 2'd2, 1'b0, g);
    chk("R3 long full compare", {31'd0, g}, 32'd0);
    clear_all();

    // R5: direction qualifier.
    wr(5'h00, 32'h40);
    for (int d = 0; d < 4; d++) begin
      wr(5'h02, ctl(1'b1, 2'(d), 1'b0, 1'b1, 2'd0));
      for (int w = 0; w < 2; w++) begin
        logic e;
        e = (d == 0) || (d == 3) || (d == 1 && w == 0) || (d == 2 && w == 1);
        bus(32'h40, 32'h0, 2'd0, 1'(w), g);
        chk("R5 direction", {31'd0, g}, {31'd0, e});
      end
    end
    clear_all();

    // R6: pass counter on last channel.
    wr(5'h0C, 32'h80);
    wr(5'h0E, ctl(1'b1, 2'd0, 1'b0, 1'b1, 2'd0));
    wr(5'h14, 32'd3);
    for (int i = 1; i <= 7; i++) begin
      bus(32'h80, 32'h0, 2'd0, 1'b0, g);
      chk("R6 pass count 3", {31'd0, g}, {31'd0, (i % 3) == 0});
    end
    wr(5'h14, 32'd0);
    bus(32'h80, 32'h0, 2'd0, 1'b0, g);
    chk("R6 pass 0 acts as 1", {31'd0, g}, 32'd1);
    bus(32'h80, 32'h0, 2'd0, 1'b0, g);
    chk("R6 pass 0 again", {31'd0, g}, 32'd1);

    // R10: write mid count clears the counter.
    wr(5'h14, 32'd3);
    bus(32'h80, 32'h0, 2'd0, 1'b0, g);
    bus(32'h80, 32'h0, 2'd0, 1'b0, g);
    wr(5'h11, 32'h0);
    bus(32'h80, 32'h0, 2'd0, 1'b0, g);
    chk("R10 counter cleared", {31'd0, g}, 32'd0);
    bus(32'h80, 32'h0, 2'd0, 1'b0, g);
    bus(32'h80, 32'h0, 2'd0, 1'b0, g);
    chk("R10 third after clear", {31'd0, g}, 32'd1);

    // R8: reset point ignored without sequential mode.
    wr(5'h14, 32'd2);
    wr(5'h13, 32'h99);
    wr(5'h10, 32'h4);
    bus(32'h80, 32'h0, 2'd0, 1'b0, g);
    bus(32'h99, 32'h0, 2'd0, 1'b0, g);
    chk("R8 rp no break", {31'd0, g}, 32'd0);
    bus(32'h80, 32'h0, 2'd0, 1'b0, g);
    chk("R8 rp ignored non-seq", {31'd0, g}, 32'd1);

    // R7: sequential order over channels 0..3.
    for (int c = 0; c < 4; c++) begin
      wr(5'(4*c), 32'h10 * (c + 1));
      wr(5'(4*c+2), ctl(1'b1, 2'd0, 1'b0, 1'b1, 2'd0));
    end
    wr(5'h14, 32'd1);
    wr(5'h10, 32'h1);
    bus(32'h40, 32'h0, 2'd0, 1'b0, g);
    chk("R7 last first no break", {31'd0, g}, 32'd0);
    bus(32'h20, 32'h0, 2'd0, 1'b0, g);
    chk("R7 out of turn", {31'd0, g}, 32'd0);
    for (int c = 0; c < 4; c++) begin
      bus(32'h10 * (c + 1), 32'h0, 2'd0, 1'b0, g);
      chk("R7 in order", {31'd0, g}, {31'd0, c == 3});
    end
    bus(32'h40, 32'h0, 2'd0, 1'b0, g);
    chk("R7 restart after break", {31'd0, g}, 32'd0);

    // R8: reset point returns to start.
    wr(5'h10, 32'h5);
    bus(32'h10, 32'h0, 2'd0, 1'b0, g);
    bus(32'h20, 32'h0, 2'd0, 1'b0, g);
    bus(32'h99, 32'h0, 2'd0, 1'b0, g);
    bus(32'h30, 32'h0, 2'd0, 1'b0, g);
    bus(32'h40, 32'h0, 2'd0, 1'b0, g);
    chk("R8 rp resets sequence", {31'd0, g}, 32'd0);
    for (int c = 0; c < 4; c++) bus(32'h10 * (c + 1), 32'h0, 2'd0, 1'b0, g);
    chk("R8 full run after rp", {31'd0, g}, 32'd1);
    wr(5'h13, 32'h40);
    for (int c = 0; c < 4; c++) bus(32'h10 * (c + 1), 32'h0, 2'd0, 1'b0, g);
    chk("R8 rp beats last channel", {31'd0, g}, 32'd0);

    // R10: write mid sequence clears the stage.
    wr(5'h10, 32'h1);
    for (int c = 0; c < 3; c++) bus(32'h10 * (c + 1), 32'h0, 2'd0, 1'b0, g);
    wr(5'h11, 32'h0);
    bus(32'h40, 32'h0, 2'd0, 1'b0, g);
    chk("R10 stage cleared", {31'd0, g}, 32'd0);

    // R9: address range.
    wr(5'h11, 32'h1000);
    wr(5'h12, 32'h10FF);
    wr(5'h10, 32'h2);
    bus(32'h0FFF, 32'h0, 2'd0, 1'b0, g);
    chk("R9 below low", {31'd0, g}, 32'd0);
    bus(32'h1000, 32'h0, 2'd1, 1'b1, g);
    chk("R9 low bound", {31'd0, g}, 32'd1);
    bus(32'h10FF, 32'h0, 2'd2, 1'b0, g);
    chk("R9 high bound", {31'd0, g}, 32'd1);
    bus(32'h1100, 32'h0, 2'd0, 1'b0, g);
    chk("R9 above high", {31'd0, g}, 32'd0);
    wr(5'h10, 32'h3);
    bus(32'h1080, 32'h0, 2'd0, 1'b0, g);
    chk("R9 range ignored in seq", {31'd0, g}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule